// File: doc/BRIEF.md
# Page Translation Buffer

A small, fully associative buffer that turns a 32-bit virtual address into a physical address. Software loads every entry through a write port. Each write goes to one entry, chosen by index, and fills either the tag half or the data half of that entry. A lookup presents a virtual address, the current process ID and the kind of access (instruction fetch, load or store). In the same cycle the block returns hit or miss, the translated address with any extended upper bits, the storage attributes of the matching entry, and a protection-fault flag.

Each entry has its own page size, from 1 KB to 16 MB in steps of four. The page size sets how many upper address bits are compared against the tag. It also sets how many low bits pass straight through as the page offset. An entry with a process ID of zero is global and matches any current process. When several entries match, the one with the lowest index is used. The physical address can be widened by an extension field in the data half. That field is copied verbatim into the address bits above bit 31.

Top module: `xlate_buf`

## Requirements
- R1: Reset, whether asserted at start-up or mid-run, leaves every entry invalid, so every later lookup misses until entries are rewritten. Writes are accepted from the third rising clock edge after reset is released.
- R2: An entry hits only if its valid bit is set and its tag equals the compared virtual address bits. When no entry hits, `lk_miss` is 1 and `lk_hit` is 0. Otherwise `lk_hit` is 1 and `lk_miss` is 0.
- R3: The 3-bit size code s gives a page of 2^(10+2s) bytes (0 = 1 KB up to 7 = 16 MB). Only virtual address bits 31 down to 10+2s take part in the tag compare. Tag bits below that position are ignored.
- R4: On a hit, physical address bits below 10+2s equal the virtual address bits. Bits 31 down to 10+2s come from the real page number, which represents address bits 31..10. Real page number bits below the page size are discarded.
- R5: An entry with a non-zero process ID matches only when it equals `lk_pid`. An entry with process ID zero matches any `lk_pid`.
- R6: When more than one entry matches, the lowest-index entry supplies the address, the attributes and the permissions.
- R7: Access kind codes are 0 = fetch, 1 = load, 2 = store (3 behaves as load). A hit on a fetch with the execute permit clear raises `lk_fault`. A hit on a store with the write permit clear raises `lk_fault`. A load never faults.
- R8: On a miss, `lk_fault` is 0.
- R9: `lk_pa` bits above 31 are copied unchanged from the extension field of the matching entry.
- R10: `lk_attr` is {write-through, cache-inhibit, coherent, guarded, endian, user} from bit 5 down to bit 0 of the matching entry. On a miss, `lk_attr` and `lk_pa` are all zero.
- R11: The write port acts on the rising edge when `wr_en` = 1, and the lookup sees the result in the next cycle. `wr_half` = 1 writes the tag half: tag in bits 35:14, size 13:11, valid 10, endian 9, user 8, process ID 7:0. `wr_half` = 0 writes the data half: extension in bits 39:32, real page number 31:10, execute 9, write 8, zone 7:4, write-through 3, cache-inhibit 2, coherent 1, guarded 0. Writing a tag half with valid = 0 invalidates the entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Current process ID |
| lk_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| wr_en | input | 1 | Entry write enable |
| wr_idx | input | 4 | Index of the entry to write |
| wr_half | input | 1 | 1 = tag half, 0 = data half |
| wr_data | input | 40 | Contents for the selected half |
| lk_hit | output | 1 | Some entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_fault | output | 1 | Permission violation on a hit |
| lk_pa | output | 40 | Translated physical address |
| lk_attr | output | 6 | Storage attributes of the matching entry |

## Verification
The bench loads entries with three different page sizes and checks addresses just inside and just outside each page. A wrong size mask would either cut off offset bits or alias a neighbouring page. One entry stores junk in the tag bits and real page number bits below its page size. A design that compares those tag bits would miss, and one that keeps those page number bits would corrupt the offset. Two valid entries overlap, so a wrong priority returns the higher-index translation. The bench then invalidates the lower one and expects the other translation on the next lookup. Further lookups cover:
- a global entry;
- a process ID mismatch;
- a fetch and a store on pages without the matching permit;
- a mid-run reset.

A design that faults on loads or misses, or that retains entries across reset, fails these.

// File: rtl/xb_pkg.sv
`timescale 1ns/1ps
package xb_pkg;
  localparam int VA_W       = 32;
  localparam int MIN_OFS    = 10;
  localparam int TAG_W      = VA_W - MIN_OFS;
  localparam int PID_W      = 8;
  localparam int SIZE_W     = 3;
  localparam int ATTR_W     = 6;
  localparam int DLO_W      = 32;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef struct packed {
    logic [TAG_W-1:0]  vtag;
    logic [SIZE_W-1:0] size;
    logic              valid;
    logic              endian;
    logic              user;
    logic [PID_W-1:0]  pid;
  } tag_half_t;

  localparam int TAG_HALF_W    = $bits(tag_half_t);
  localparam int TAG_VALID_POS = PID_W + 2;

  typedef struct packed {
    logic [TAG_W-1:0] rpn;
    logic             ex;
    logic             wr;
    logic [3:0]       zone;
    logic             wt;
    logic             ci;
    logic             coh;
    logic             grd;
  } data_lo_t;

  // Tag bits that take part in the compare for a given size code.
  function automatic logic [TAG_W-1:0] cmp_mask(input logic [SIZE_W-1:0] size);
    cmp_mask = {TAG_W{1'b1}} << {size, 1'b0};
  endfunction

  // Virtual address bits that pass through as the page offset.
  function automatic logic [VA_W-1:0] ofs_mask(input logic [SIZE_W-1:0] size);
    logic [4:0] shamt;
    shamt    = 5'(MIN_OFS) + {1'b0, size, 1'b0};
    ofs_mask = ~({VA_W{1'b1}} << shamt);
  endfunction
endpackage

// File: rtl/xb_rst_sync.sv
`timescale 1ns/1ps
module xb_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/xb_entry_store.sv
`timescale 1ns/1ps
module xb_entry_store
  import xb_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int DH_W  = 40,
  parameter int WD_W  = 40,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_half,
  input  logic [WD_W-1:0]             wr_data,
  output tag_half_t [N_ENT-1:0]       tags_o,
  output logic [N_ENT-1:0][DH_W-1:0]  datas_o
);
  tag_half_t wr_tag;
  assign wr_tag = tag_half_t'(wr_data[TAG_HALF_W-1:0]);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic      sel;
    logic      tag_we;
    logic      dat_we;
    logic      valid_q;
    logic      valid_d;
    tag_half_t tag_q;
    logic [DH_W-1:0] dat_q;
    tag_half_t tag_view;

    assign sel     = wr_en && (wr_idx == IDX_W'(e));
    assign tag_we  = sel && wr_half;
    assign dat_we  = sel && !wr_half;
    assign valid_d = wr_tag.valid;

    // Valid bits carry the reset; payload storage does not.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      valid_q <= 1'b0;
      else if (tag_we) valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (tag_we) tag_q <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (dat_we) dat_q <= wr_data[DH_W-1:0];
    end

    always_comb begin
      tag_view       = tag_q;
      tag_view.valid = valid_q;
    end

    assign tags_o[e]  = tag_view;
    assign datas_o[e] = dat_q;
  end
endmodule

// File: rtl/xb_match.sv
`timescale 1ns/1ps
module xb_match
  import xb_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  tag_half_t [N_ENT-1:0] tags_i,
  input  logic [VA_W-1:0]       va_i,
  input  logic [PID_W-1:0]      pid_i,
  output logic [N_ENT-1:0]      match_o
);
  logic [TAG_W-1:0] vpn;
  assign vpn = va_i[VA_W-1:MIN_OFS];

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    tag_half_t        t;
    logic [TAG_W-1:0] diff;
    logic             tag_eq;
    logic             pid_ok;

    assign t      = tags_i[e];
    assign diff   = (t.vtag ^ vpn) & cmp_mask(t.size);
    assign tag_eq = (diff == '0);
    assign pid_ok = (t.pid == '0) || (t.pid == pid_i);
    assign match_o[e] = t.valid && tag_eq && pid_ok;
  end
endmodule

// File: rtl/xb_select.sv
`timescale 1ns/1ps
module xb_select
  import xb_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int EXT_W = 8,
  localparam int DH_W = DLO_W + EXT_W,
  localparam int PA_W = VA_W + EXT_W
) (
  input  logic [N_ENT-1:0]            match_i,
  input  tag_half_t [N_ENT-1:0]       tags_i,
  input  logic [N_ENT-1:0][DH_W-1:0]  datas_i,
  input  logic [VA_W-1:0]             va_i,
  input  acc_e                        kind_i,
  output logic [N_ENT-1:0]            grant_o,
  output logic                        hit_o,
  output logic                        fault_o,
  output logic [PA_W-1:0]             pa_o,
  output logic [ATTR_W-1:0]           attr_o
);
  logic [TAG_HALF_W-1:0] sel_tag_v;
  logic [DH_W-1:0]       sel_dat;
  tag_half_t             sel_tag;
  data_lo_t              dlo;
  logic [VA_W-1:0]       ofsm;
  logic [VA_W-1:0]       base;
  logic [VA_W-1:0]       pa_lo;
  logic                  bad_fetch;
  logic                  bad_store;

  // Isolate the lowest set match bit.
  assign grant_o = match_i & (~match_i + N_ENT'(1));
  assign hit_o   = |match_i;

  always_comb begin
    sel_tag_v = '0;
    sel_dat   = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if (grant_o[e]) begin
        sel_tag_v = sel_tag_v | tags_i[e];
        sel_dat   = sel_dat | datas_i[e];
      end
    end
  end

  assign sel_tag = tag_half_t'(sel_tag_v);
  assign dlo     = data_lo_t'(sel_dat[DLO_W-1:0]);

  always_comb begin
    ofsm  = ofs_mask(sel_tag.size);
    base  = {dlo.rpn, {MIN_OFS{1'b0}}};
    pa_lo = (base & ~ofsm) | (va_i & ofsm);
  end

  if (EXT_W > 0) begin : g_ext
    assign pa_o = hit_o ? {sel_dat[DLO_W +: EXT_W], pa_lo} : '0;
  end else begin : g_noext
    assign pa_o = hit_o ? pa_lo : '0;
  end

  assign attr_o = {dlo.wt, dlo.ci, dlo.coh, dlo.grd, sel_tag.endian, sel_tag.user};

  always_comb begin
    bad_fetch = (kind_i == ACC_FETCH) && !dlo.ex;
    bad_store = (kind_i == ACC_STORE) && !dlo.wr;
    fault_o   = hit_o && (bad_fetch || bad_store);
  end

  logic unused_sel;
  assign unused_sel = ^{sel_tag.vtag, sel_tag.pid, sel_tag.valid, dlo.zone};
endmodule

// File: rtl/xlate_buf.sv
`timescale 1ns/1ps
module xlate_buf
  import xb_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int EXT_W = 8,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int DH_W  = DLO_W + EXT_W,
  localparam int WD_W  = (DH_W > TAG_HALF_W) ? DH_W : TAG_HALF_W,
  localparam int PA_W  = VA_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic [1:0]        lk_kind,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_half,
  input  logic [WD_W-1:0]   wr_data,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_pa,
  output logic [ATTR_W-1:0] lk_attr
);
  logic                       rst_n_s;
  tag_half_t [N_ENT-1:0]      tags;
  logic [N_ENT-1:0][DH_W-1:0] datas;
  logic [N_ENT-1:0]           match_vec;
  logic [N_ENT-1:0]           grant_vec;
  acc_e                       kind;
  logic                       hit;

  assign kind = acc_e'(lk_kind);

  xb_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  xb_entry_store #(.N_ENT(N_ENT), .DH_W(DH_W), .WD_W(WD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_half (wr_half),
    .wr_data (wr_data),
    .tags_o  (tags),
    .datas_o (datas)
  );

  xb_match #(.N_ENT(N_ENT)) u_match (
    .tags_i  (tags),
    .va_i    (lk_va),
    .pid_i   (lk_pid),
    .match_o (match_vec)
  );

  xb_select #(.N_ENT(N_ENT), .EXT_W(EXT_W)) u_sel (
    .match_i (match_vec),
    .tags_i  (tags),
    .datas_i (datas),
    .va_i    (lk_va),
    .kind_i  (kind),
    .grant_o (grant_vec),
    .hit_o   (hit),
    .fault_o (lk_fault),
    .pa_o    (lk_pa),
    .attr_o  (lk_attr)
  );

  assign lk_hit  = hit;
  assign lk_miss = !hit;
endmodule

// File: rtl/xb_chk.sv
`timescale 1ns/1ps
module xb_chk
  import xb_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int EXT_W = 8,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int DH_W  = DLO_W + EXT_W,
  localparam int WD_W  = (DH_W > TAG_HALF_W) ? DH_W : TAG_HALF_W,
  localparam int PA_W  = VA_W + EXT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VA_W-1:0]  lk_va,
  input logic [1:0]       lk_kind,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_fault,
  input logic [PA_W-1:0]  lk_pa,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_half,
  input logic [WD_W-1:0]  wr_data,
  input logic [N_ENT-1:0] match_vec,
  input logic [N_ENT-1:0] grant_vec
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lk_miss && !lk_hit));

  // R6
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R6
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |-> ((match_vec & (grant_vec - N_ENT'(1))) == '0));

  // R2
  hit_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($countones(grant_vec) == 1));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[MIN_OFS-1:0] == lk_va[MIN_OFS-1:0]));

  // R7
  load_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_kind == ACC_LOAD) |-> !lk_fault);

  // R8
  miss_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> !lk_fault);

  // R11
  invalidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_half && !wr_data[TAG_VALID_POS]) |=> !match_vec[$past(wr_idx)]);
endmodule

bind xlate_buf xb_chk #(.N_ENT(N_ENT), .EXT_W(EXT_W)) u_xb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_va     (lk_va),
  .lk_kind   (lk_kind),
  .lk_hit    (lk_hit),
  .lk_miss   (lk_miss),
  .lk_fault  (lk_fault),
  .lk_pa     (lk_pa),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_half   (wr_half),
  .wr_data   (wr_data),
  .match_vec (match_vec),
  .grant_vec (grant_vec)
);

// File: tb/xlate_buf_tb_top.sv
`timescale 1ns/1ps
module xlate_buf_tb_top;
  localparam int N_ENT = 16;
  localparam int EXT_W = 8;
  localparam int PA_W  = 32 + EXT_W;
  localparam int WD_W  = 40;
  localparam int NVEC  = 14;

  logic            clk;
  logic            rst_n;
  logic [31:0]     lk_va;
  logic [7:0]      lk_pid;
  logic [1:0]      lk_kind;
  logic            wr_en;
  logic [3:0]      wr_idx;
  logic            wr_half;
  logic [WD_W-1:0] wr_data;
  logic            lk_hit;
  logic            lk_miss;
  logic            lk_fault;
  logic [PA_W-1:0] lk_pa;
  logic [5:0]      lk_attr;

  int n_chk;
  int n_err;
  bit done;

  xlate_buf #(.N_ENT(N_ENT), .EXT_W(EXT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_pid(lk_pid), .lk_kind(lk_kind),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_half(wr_half), .wr_data(wr_data),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pa(lk_pa),
    .lk_attr(lk_attr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Row: va, pid, kind, hit, fault, pa, attr  (kind 0 fetch, 1 load, 2 store)
  localparam logic [89:0] VEC [NVEC] = '{
    {32'h00010ABC, 8'd5,  2'd0, 1'b1, 1'b0, 40'h1200200ABC, 6'b100010},
    {32'h00010ABC, 8'd5,  2'd2, 1'b1, 1'b1, 40'h1200200ABC, 6'b100010},
    {32'h00010ABC, 8'd5,  2'd1, 1'b1, 1'b0, 40'h1200200ABC, 6'b100010},
    {32'h00010ABC, 8'd6,  2'd1, 1'b0, 1'b0, 40'h0,          6'b000000},
    {32'h00011ABC, 8'd5,  2'd0, 1'b0, 1'b0, 40'h0,          6'b000000},
    {32'h40ABCDEF, 8'd9,  2'd0, 1'b1, 1'b1, 40'h0080ABCDEF, 6'b010101},
    {32'h40ABCDEF, 8'h33, 2'd2, 1'b1, 1'b0, 40'h0080ABCDEF, 6'b010101},
    {32'h41ABCDEF, 8'd9,  2'd2, 1'b0, 1'b0, 40'h0,          6'b000000},
    {32'h00002123, 8'd1,  2'd1, 1'b1, 1'b0, 40'h0000102123, 6'b001000},
    {32'h00002400, 8'd1,  2'd2, 1'b1, 1'b0, 40'h0000102400, 6'b001000},
    {32'h00C3FFFF, 8'd7,  2'd1, 1'b1, 1'b0, 40'hFF0303FFFF, 6'b000000},
    {32'h00C40000, 8'd7,  2'd1, 1'b0, 1'b0, 40'h0,          6'b000000},
    {32'h00C3FFFF, 8'd8,  2'd0, 1'b0, 1'b0, 40'h0,          6'b000000},
    {32'h00C3FFFF, 8'd7,  2'd0, 1'b1, 1'b0, 40'hFF0303FFFF, 6'b000000}
  };

  function automatic logic [35:0] mk_tag(input logic [21:0] t, input logic [2:0] sz,
      input logic v, input logic en, input logic us, input logic [7:0] pid);
    mk_tag = {t, sz, v, en, us, pid};
  endfunction

  function automatic logic [39:0] mk_data(input logic [7:0] ext, input logic [21:0] rpn,
      input logic ex, input logic wp, input logic [3:0] zone,
      input logic wt, input logic ci, input logic coh, input logic grd);
    mk_data = {ext, rpn, ex, wp, zone, wt, ci, coh, grd};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
      input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put_tag(input int idx, input logic [35:0] t);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_half = 1'b1;
    wr_data = '0; wr_data[35:0] = t;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_data(input int idx, input logic [39:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_half = 1'b0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] pid, input logic [1:0] kind);
    @(negedge clk);
    lk_va = va; lk_pid = pid; lk_kind = kind;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; lk_va = '0; lk_pid = '0; lk_kind = '0;
    wr_en = 1'b0; wr_idx = '0; wr_half = 1'b0; wr_data = '0;
    n_chk = 0; n_err = 0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: nothing valid after start-up reset
    look(32'h00010ABC, 8'd5, 2'd0);
    chk("R1", "hit after reset", 64'(lk_hit), 64'd0);
    chk("R1", "miss after reset", 64'(lk_miss), 64'd1);
    chk("R8", "fault after reset", 64'(lk_fault), 64'd0);
    chk("R10", "attr after reset", 64'(lk_attr), 64'd0);

    // R11: load entries through both halves
    put_tag(0, mk_tag(22'h40, 3'd1, 1'b1, 1'b1, 1'b0, 8'd5));
    put_data(0, mk_data(8'h12, 22'h800, 1'b1, 1'b0, 4'hA, 1'b1, 1'b0, 1'b0, 1'b0));
    put_tag(9, mk_tag(22'h1003FF, 3'd7, 1'b1, 1'b0, 1'b1, 8'd0));
    put_data(9, mk_data(8'h00, 22'h200155, 1'b0, 1'b1, 4'h3, 1'b0, 1'b1, 1'b0, 1'b1));
    put_tag(3, mk_tag(22'h0, 3'd2, 1'b1, 1'b0, 1'b0, 8'd0));
    put_data(3, mk_data(8'h00, 22'h400, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0));
    put_tag(5, mk_tag(22'h8, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0));
    put_data(5, mk_data(8'h00, 22'h14, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0));
    put_tag(15, mk_tag(22'h3000, 3'd4, 1'b1, 1'b0, 1'b0, 8'd7));
    put_data(15, mk_data(8'hFF, 22'hC000, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0));

    // R2 R3 R4 R5 R6 R7 R8 R9 R10: table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [89:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("row %0d R2 R3 R4 R5 R6 R7 R8 R9 R10", i);
      look(v[89:58], v[57:50], v[49:48]);
      chk(tag, "hit", 64'(lk_hit), 64'(v[47]));
      chk(tag, "miss", 64'(lk_miss), 64'(!v[47]));
      chk(tag, "fault", 64'(lk_fault), 64'(v[46]));
      chk(tag, "pa", 64'(lk_pa), 64'(v[45:6]));
      chk(tag, "attr", 64'(lk_attr), 64'(v[5:0]));
    end

    // R11: invalidate entry 3, entry 5 now serves the overlap
    put_tag(3, mk_tag(22'h0, 3'd2, 1'b0, 1'b0, 1'b0, 8'd0));
    look(32'h00002123, 8'd1, 2'd1);
    chk("R11", "hit after invalidate", 64'(lk_hit), 64'd1);
    chk("R11", "pa after invalidate", 64'(lk_pa), 64'h0000005123);
    chk("R11", "attr after invalidate", 64'(lk_attr), 64'd0);
    look(32'h00002400, 8'd1, 2'd2);
    chk("R11", "invalidated page miss", 64'(lk_miss), 64'd1);

    // R1: mid-run reset drops all entries
    do_reset();
    look(32'h40ABCDEF, 8'd9, 2'd0);
    chk("R1", "miss after mid-run reset", 64'(lk_miss), 64'd1);
    chk("R8", "fault after mid-run reset", 64'(lk_fault), 64'd0);
    look(32'h00C3FFFF, 8'd7, 2'd1);
    chk("R1", "second entry after reset", 64'(lk_hit), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule